// File: doc/BRIEF.md
# Single-Precision to Signed 64-Bit Integer Converter

This unit takes a 128-bit vector holding four single-precision floats and converts only the lowest lane, bits 31:0, to a two's-complement 64-bit integer. The three upper lanes do not affect the result. A 2-bit mode input selects one of four IEEE rounding directions. A separate chop input forces rounding toward zero, whatever the mode input says.

The conversion runs in one cycle. Operands are presented with a valid strobe, and the result, an invalid flag and an inexact flag appear from output registers on the next clock edge. They hold their values until the next strobe.

Some inputs have no representable result: NaN, either infinity, or any value whose rounded magnitude does not fit in a signed 64-bit integer. For these the unit returns the integer-indefinite pattern 0x8000_0000_0000_0000 and raises the invalid flag. Denormal inputs are treated as tiny nonzero values and are rounded like any other value.

Top module: `fp32_to_int64`

## Requirements
- R1: Only vecIn[31:0] is converted. Changing vecIn[127:32] has no effect on intOut, invalidFlag or inexactFlag.
- R2: Mode code 2'b00 rounds to the nearest integer, with ties going to the even value. For example, -33.5 gives -34, -34.5 gives -34, 2.5 gives 2 and 1.5 gives 2.
- R3: Mode code 2'b01 rounds toward minus infinity. For example, 10.75 gives 10 and -5.75 gives -6.
- R4: Mode code 2'b10 rounds toward plus infinity. For example, 10.75 gives 11 and -5.75 gives -5.
- R5: Mode code 2'b11 rounds toward zero. When truncMode is 1, the unit rounds toward zero whatever rndMode holds. For example, -33.5 gives -33 and 10.75 gives 10.
- R6: A NaN or infinite input returns 64'h8000_0000_0000_0000 with invalidFlag = 1 and inexactFlag = 0.
- R7: A value of magnitude 2^63 or more returns 64'h8000_0000_0000_0000 with invalidFlag = 1. The one exception is exactly -2^63, which converts to that same pattern with invalidFlag = 0.
- R8: inexactFlag is 1 exactly when a valid result discarded a nonzero fraction. Exact values such as 0, -0, 42.0, 4.0e10 and 2147483520.0 convert without it.
- R9: Denormals, where the exponent field is 0, convert as tiny nonzero values. They give 0 under nearest-even, +1 toward plus infinity when positive, and -1 toward minus infinity when negative. In every case inexactFlag = 1.
- R10: After reset, outValid, intOut and both flags are 0. A result appears, with outValid high, one cycle after inValid. When inValid is low, outValid is 0 and the result holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Operand strobe |
| vecIn | input | 128 | Four packed floats; lane 0 in bits 31:0 |
| rndMode | input | 2 | Rounding direction: 00 nearest-even, 01 down, 10 up, 11 toward zero |
| truncMode | input | 1 | Forces rounding toward zero |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| intOut | output | 64 | Signed integer result |
| invalidFlag | output | 1 | NaN, infinity or out-of-range input |
| inexactFlag | output | 1 | Nonzero fraction discarded |

## Verification
The bench drives exact halfway values of both signs, including ties that sit on even and on odd integers. A design that rounds ties away from zero, or that applies a directed mode to the magnitude instead of the signed value, returns a result that is off by one.

It covers the boundary at 2^63 from both sides: the largest float below 2^63, +2^63, and -2^63. A faulty overflow compare either raises a false invalid on -2^63 or lets +2^63 wrap to a negative number.

Denormals, signed zeros, NaN and both infinities check the special-exponent decode. Packing NaN patterns into the upper lanes exposes any lane-select error. The truncate input is combined with each other mode to catch a priority inversion.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int INT_W  = 64;
  localparam int LANE_W = 1 + EXP_W + FRAC_W;
  localparam int LANES  = 4;
  localparam int VEC_W  = LANE_W * LANES;
  localparam int MANT_W = FRAC_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rndMode_e;

  typedef struct packed {
    logic     load;
    rndMode_e mode;
  } cvtStrobe_t;
endpackage

// File: rtl/cvt_ctrl.sv
module cvt_ctrl
  import cvt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] rndMode,
  input  logic       truncMode,
  output cvtStrobe_t strobe,
  output logic       outValid
);
  // Chop input has priority over the selected direction.
  always_comb begin
    strobe.load = inValid;
    strobe.mode = truncMode ? RND_ZERO : rndMode_e'(rndMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/cvt_datapath.sv
module cvt_datapath
  import cvt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LANE_W-1:0] laneIn,
  input  cvtStrobe_t        strobe,
  output logic [INT_W-1:0]  intOut,
  output logic              invalidFlag,
  output logic              inexactFlag
);
  localparam int FIX_PT = BIAS + FRAC_W;        // exponent where value == mantissa
  localparam int EXT_W  = MANT_W + FIX_PT;      // right-shift workspace
  localparam int LSH_W  = $clog2(INT_W);
  localparam logic [EXP_W:0] FIX_PT_E = (EXP_W+1)'(FIX_PT);
  localparam logic [EXP_W:0] OVF_E    = (EXP_W+1)'(BIAS + INT_W - 1);
  localparam logic [LSH_W-1:0] MAX_LSH = LSH_W'(INT_W - MANT_W);
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

  logic              sgn;
  logic [EXP_W-1:0]  expF;
  logic [FRAC_W-1:0] frac;
  logic [MANT_W-1:0] mant;
  logic [EXP_W:0]    expEff;
  logic              isSpecial, bigPath, overflow;
  logic [LSH_W-1:0]  lshAmt;
  logic [EXP_W:0]    rshAmt;
  logic [EXT_W-1:0]  ext;
  logic [INT_W-1:0]  mag, magR, resVal;
  logic              rndBit, stkBit, lsbBit, incr;

  assign sgn  = laneIn[LANE_W-1];
  assign expF = laneIn[LANE_W-2 -: EXP_W];
  assign frac = laneIn[FRAC_W-1:0];

  always_comb begin
    mant      = {(expF != '0), frac};
    expEff    = (expF == '0) ? (EXP_W+1)'(1) : {1'b0, expF};
    isSpecial = &expF;
    bigPath   = expEff >= FIX_PT_E;
    overflow  = (expEff > OVF_E) || ((expEff == OVF_E) && !(sgn && frac == '0));

    lshAmt = MAX_LSH;
    if (bigPath && expEff < OVF_E) lshAmt = LSH_W'(expEff - FIX_PT_E);
    rshAmt = bigPath ? '0 : (FIX_PT_E - expEff);
    ext    = {mant, {FIX_PT{1'b0}}} >> rshAmt;

    if (bigPath) begin
      mag    = INT_W'(mant) << lshAmt;
      rndBit = 1'b0;
      stkBit = 1'b0;
    end else begin
      mag    = INT_W'(ext[EXT_W-1 -: MANT_W]);
      rndBit = ext[FIX_PT-1];
      stkBit = |ext[FIX_PT-2:0];
    end
    lsbBit = mag[0];

    unique case (strobe.mode)
      RND_NEAR: incr = rndBit & (stkBit | lsbBit);
      RND_DOWN: incr = (rndBit | stkBit) & sgn;
      RND_UP:   incr = (rndBit | stkBit) & ~sgn;
      default:  incr = 1'b0;
    endcase

    magR   = mag + INT_W'(incr);
    resVal = sgn ? ('0 - magR) : magR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intOut      <= '0;
      invalidFlag <= 1'b0;
      inexactFlag <= 1'b0;
    end else if (strobe.load) begin
      if (isSpecial || overflow) begin
        intOut      <= INDEF;
        invalidFlag <= 1'b1;
        inexactFlag <= 1'b0;
      end else begin
        intOut      <= resVal;
        invalidFlag <= 1'b0;
        inexactFlag <= rndBit | stkBit;
      end
    end
  end
endmodule

// File: rtl/fp32_to_int64.sv
module fp32_to_int64
  import cvt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [VEC_W-1:0]  vecIn,
  input  logic [1:0]        rndMode,
  input  logic              truncMode,
  output logic              outValid,
  output logic [INT_W-1:0]  intOut,
  output logic              invalidFlag,
  output logic              inexactFlag
);
  cvtStrobe_t strobe;

  cvt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .rndMode(rndMode),
    .truncMode(truncMode), .strobe(strobe), .outValid(outValid)
  );

  cvt_datapath u_dp (
    .clk(clk), .rstN(rstN), .laneIn(vecIn[LANE_W-1:0]), .strobe(strobe),
    .intOut(intOut), .invalidFlag(invalidFlag), .inexactFlag(inexactFlag)
  );
endmodule

// File: rtl/fp32_to_int64_chk.sv
module fp32_to_int64_chk
  import cvt_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [VEC_W-1:0] vecIn,
  input logic [1:0]       rndMode,
  input logic             truncMode,
  input logic             outValid,
  input logic [INT_W-1:0] intOut,
  input logic             invalidFlag,
  input logic             inexactFlag
);
  p_upper_ignored_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid && $past(inValid) && vecIn[LANE_W-1:0] == $past(vecIn[LANE_W-1:0])
    && vecIn[VEC_W-1:LANE_W] != $past(vecIn[VEC_W-1:LANE_W])
    && rndMode == $past(rndMode) && truncMode == $past(truncMode)
    |=> $stable(intOut) && $stable(invalidFlag) && $stable(inexactFlag));

  p_chop_small_r5: assert property (@(posedge clk) disable iff (!rstN)
    inValid && truncMode && vecIn[30:23] < 8'd127 |=> intOut == '0 && !invalidFlag);

  p_special_r6: assert property (@(posedge clk) disable iff (!rstN)
    inValid && vecIn[30:23] == 8'hFF |=> invalidFlag && !inexactFlag);

  p_indef_value_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && invalidFlag |-> intOut == {1'b1, {(INT_W-1){1'b0}}});

  p_zero_exact_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid && vecIn[30:0] == '0 |=> intOut == '0 && !inexactFlag && !invalidFlag);

  p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    invalidFlag |-> !inexactFlag);

  p_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid && $stable(intOut) && $stable(invalidFlag));
endmodule

bind fp32_to_int64 fp32_to_int64_chk u_chk (.*);

// File: tb/tb_fp32_to_int64.sv
module tb_fp32_to_int64;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] vecIn = '0;
  logic [1:0]   rndMode = 2'b00;
  logic         truncMode = 1'b0;
  logic         outValid;
  logic [63:0]  intOut;
  logic         invalidFlag, inexactFlag;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  localparam logic [63:0] INDEF = 64'h8000_0000_0000_0000;
  localparam logic [95:0] FILL  = {3{32'h3F80_0000}};

  always #2.5 clk = ~clk;

  fp32_to_int64 dut (.*);

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One conversion: drive at negedge, result latched at the next posedge.
  task automatic runCase(string req, logic [127:0] v, logic [1:0] m, logic t,
                         logic [63:0] expInt, logic expInv, logic expInx);
    @(negedge clk);
    vecIn = v; rndMode = m; truncMode = t; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(req, "intOut", intOut, expInt);
    check(req, "invalid", 64'(invalidFlag), 64'(expInv));
    check(req, "inexact", 64'(inexactFlag), 64'(expInx));
    check("R10", "outValid", 64'(outValid), 64'd1);
  endtask

  task automatic testReset();
    check("R10", "reset outValid", 64'(outValid), 64'd0);
    check("R10", "reset intOut", intOut, 64'd0);
    check("R10", "reset flags", 64'({invalidFlag, inexactFlag}), 64'd0);
  endtask

  task automatic testHold();
    logic [63:0] prev;
    runCase("R10", {FILL, 32'h4228_0000}, 2'b00, 1'b0, 64'd42, 1'b0, 1'b0);
    prev = intOut;
    @(negedge clk);
    vecIn = {FILL, 32'h7FC0_0000};
    @(negedge clk);
    check("R10", "outValid low", 64'(outValid), 64'd0);
    check("R10", "held result", intOut, prev);
  endtask

  task automatic testLane();
    runCase("R1", {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'h4228_0000}, 2'b00, 1'b0, 64'd42, 1'b0, 1'b0);
    runCase("R1", {96'h7F80_0000_7FC0_0000_0000_0001, 32'hC206_0000}, 2'b01, 1'b0, -64'sd34, 1'b0, 1'b1);
    runCase("R1", {FILL, 32'h7FC0_0000}, 2'b00, 1'b0, INDEF, 1'b1, 1'b0);
  endtask

  task automatic testNearest();
    runCase("R2", {FILL, 32'hC206_0000}, 2'b00, 1'b0, -64'sd34, 1'b0, 1'b1);
    runCase("R2", {FILL, 32'hC20A_0000}, 2'b00, 1'b0, -64'sd34, 1'b0, 1'b1);
    runCase("R2", {FILL, 32'h4020_0000}, 2'b00, 1'b0, 64'd2, 1'b0, 1'b1);
    runCase("R2", {FILL, 32'h3FC0_0000}, 2'b00, 1'b0, 64'd2, 1'b0, 1'b1);
    runCase("R2", {FILL, 32'h3F00_0000}, 2'b00, 1'b0, 64'd0, 1'b0, 1'b1);
    runCase("R2", {FILL, 32'h412C_0000}, 2'b00, 1'b0, 64'd11, 1'b0, 1'b1);
  endtask

  task automatic testDown();
    runCase("R3", {FILL, 32'h412C_0000}, 2'b01, 1'b0, 64'd10, 1'b0, 1'b1);
    runCase("R3", {FILL, 32'hC0B8_0000}, 2'b01, 1'b0, -64'sd6, 1'b0, 1'b1);
  endtask

  task automatic testUp();
    runCase("R4", {FILL, 32'h412C_0000}, 2'b10, 1'b0, 64'd11, 1'b0, 1'b1);
    runCase("R4", {FILL, 32'hC0B8_0000}, 2'b10, 1'b0, -64'sd5, 1'b0, 1'b1);
  endtask

  task automatic testChop();
    runCase("R5", {FILL, 32'hC206_0000}, 2'b11, 1'b0, -64'sd33, 1'b0, 1'b1);
    runCase("R5", {FILL, 32'hC206_0000}, 2'b00, 1'b1, -64'sd33, 1'b0, 1'b1);
    runCase("R5", {FILL, 32'h412C_0000}, 2'b10, 1'b1, 64'd10, 1'b0, 1'b1);
    runCase("R5", {FILL, 32'hC0B8_0000}, 2'b01, 1'b1, -64'sd5, 1'b0, 1'b1);
  endtask

  task automatic testSpecial();
    runCase("R6", {FILL, 32'h7FC0_0000}, 2'b00, 1'b0, INDEF, 1'b1, 1'b0);
    runCase("R6", {FILL, 32'h7F80_0000}, 2'b10, 1'b0, INDEF, 1'b1, 1'b0);
    runCase("R6", {FILL, 32'hFF80_0000}, 2'b01, 1'b1, INDEF, 1'b1, 1'b0);
  endtask

  task automatic testRange();
    runCase("R7", {FILL, 32'h5F00_0000}, 2'b00, 1'b0, INDEF, 1'b1, 1'b0);
    runCase("R7", {FILL, 32'h5F00_0000}, 2'b00, 1'b1, INDEF, 1'b1, 1'b0);
    runCase("R7", {FILL, 32'hDF00_0000}, 2'b00, 1'b0, INDEF, 1'b0, 1'b0);
    runCase("R7", {FILL, 32'h5EFF_FFFF}, 2'b10, 1'b0, 64'h7FFF_FF80_0000_0000, 1'b0, 1'b0);
    runCase("R7", {FILL, 32'h5E80_0000}, 2'b00, 1'b0, 64'h4000_0000_0000_0000, 1'b0, 1'b0);
  endtask

  task automatic testExact();
    runCase("R8", {FILL, 32'h5115_02F9}, 2'b00, 1'b0, 64'd40000000000, 1'b0, 1'b0);
    runCase("R8", {FILL, 32'h4EFF_FFFF}, 2'b01, 1'b0, 64'd2147483520, 1'b0, 1'b0);
    runCase("R8", {FILL, 32'h0000_0000}, 2'b10, 1'b0, 64'd0, 1'b0, 1'b0);
    runCase("R8", {FILL, 32'h8000_0000}, 2'b01, 1'b0, 64'd0, 1'b0, 1'b0);
    runCase("R8", {FILL, 32'h4228_0000}, 2'b11, 1'b0, 64'd42, 1'b0, 1'b0);
  endtask

  task automatic testDenormal();
    runCase("R9", {FILL, 32'h0000_0001}, 2'b00, 1'b0, 64'd0, 1'b0, 1'b1);
    runCase("R9", {FILL, 32'h0000_0001}, 2'b10, 1'b0, 64'd1, 1'b0, 1'b1);
    runCase("R9", {FILL, 32'h8000_0001}, 2'b01, 1'b0, -64'sd1, 1'b0, 1'b1);
    runCase("R9", {FILL, 32'h8000_0001}, 2'b10, 1'b0, 64'd0, 1'b0, 1'b1);
    runCase("R9", {FILL, 32'h2F00_0000}, 2'b10, 1'b0, 64'd1, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testLane();
    testNearest();
    testDown();
    testUp();
    testChop();
    testSpecial();
    testRange();
    testExact();
    testDenormal();
    testHold();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule